// File: doc/BRIEF.md
# Per-Channel Raster Logic Operation Unit

This block sits at the end of a pixel pipeline and decides what gets written back to the colour buffer. Each input pixel is a pair of RGBA8 words: a source pixel, produced by the colour combiner, and a destination pixel, read from the framebuffer.

When blending is disabled, the block applies one of sixteen bitwise operations, chosen by a 4-bit code, to every 8-bit channel of the pair on its own. When blending is enabled, the block forwards a blend result computed elsewhere, and the op code has no effect. Logic operations and blending are therefore mutually exclusive.

The input side and the output side each use a valid/ready stream handshake, and the result is held in a single output register.

Stream rules:
- An input beat is taken on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty, or its current beat is being taken downstream in the same cycle.
- Once `out_valid` is high, the output beat holds steady until `out_ready` takes it.

Top module: `rop_unit`

## Requirements
- R1: With `blend_en` low, codes 0 to 7 give, per channel: 0 all zeros, 1 src&dst, 2 src&~dst, 3 src, 4 all ones (255), 5 ~src, 6 dst, 7 ~dst.
- R2: With `blend_en` low, codes 8 to 15 give, per channel: 8 ~(src&dst), 9 src|dst, 10 ~(src|dst), 11 src^dst, 12 ~(src^dst), 13 ~src&dst, 14 src|~dst, 15 ~src|dst.
- R3: Channels are packed as R in bits 7:0, G in 15:8, B in 23:16 and A in 31:24. Each channel's result depends only on that channel's src and dst bits.
- R4: With `blend_en` high, the output equals `blend_pixel`, whatever the op code is.
- R5: A beat accepted at one clock edge appears with `out_valid` high right after that edge, which is one cycle of latency.
- R6: While `out_valid` is high and `out_ready` is low, `out_pixel` and `out_valid` hold and `in_ready` is low.
- R7: `op_code` and `blend_en` take effect only on the cycle where their beat is accepted. Changing them afterwards does not alter an output already produced.
- R8: After reset, `out_valid` is low and `in_ready` is high.
- R9: When `out_ready` is high, `in_ready` is high, so a full-rate stream passes without bubbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Unit can take an input beat |
| src_pixel | input | 32 | Combiner pixel (RGBA8) |
| dst_pixel | input | 32 | Framebuffer pixel (RGBA8) |
| blend_pixel | input | 32 | Precomputed blend result |
| op_code | input | 4 | Logic operation select |
| blend_en | input | 1 | 1 selects the blend result, 0 selects the logic op result |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Downstream takes the result |
| out_pixel | output | 32 | Result pixel |

## Verification
The in-design properties check the following on every cycle:
- the output is held under back-pressure;
- an accepted beat is followed by a valid output;
- blend pass-through takes effect;
- the set and copy codes produce their values.

The full table of sixteen operations, channel independence with distinct bytes per channel, and ignored late changes to the op code are shown only by the bench's scenarios. The bench compares every output beat against a model written from the operation table, under both steady and random downstream stalls.

// File: rtl/rop_pkg.sv
package rop_pkg;
  localparam int CH_W   = 8;
  localparam int NUM_CH = 4;

  typedef enum logic [3:0] {
    ROP_ZERO     = 4'd0,
    ROP_AND      = 4'd1,
    ROP_AND_NDST = 4'd2,
    ROP_SRC      = 4'd3,
    ROP_ONES     = 4'd4,
    ROP_NSRC     = 4'd5,
    ROP_DST      = 4'd6,
    ROP_NDST     = 4'd7,
    ROP_NAND     = 4'd8,
    ROP_OR       = 4'd9,
    ROP_NOR      = 4'd10,
    ROP_XOR      = 4'd11,
    ROP_XNOR     = 4'd12,
    ROP_NSRC_AND = 4'd13,
    ROP_OR_NDST  = 4'd14,
    ROP_NSRC_OR  = 4'd15
  } rop_code_e;
endpackage

// File: rtl/rop_lane.sv
module rop_lane
  import rop_pkg::*;
#(
  parameter int W = CH_W
) (
  input  logic [3:0]   code,
  input  logic [W-1:0] src,
  input  logic [W-1:0] dst,
  output logic [W-1:0] res
);
  always_comb begin
    unique case (rop_code_e'(code))
      ROP_ZERO:     res = '0;
      ROP_AND:      res = src & dst;
      ROP_AND_NDST: res = src & ~dst;
      ROP_SRC:      res = src;
      ROP_ONES:     res = '1;
      ROP_NSRC:     res = ~src;
      ROP_DST:      res = dst;
      ROP_NDST:     res = ~dst;
      ROP_NAND:     res = ~(src & dst);
      ROP_OR:       res = src | dst;
      ROP_NOR:      res = ~(src | dst);
      ROP_XOR:      res = src ^ dst;
      ROP_XNOR:     res = ~(src ^ dst);
      ROP_NSRC_AND: res = ~src & dst;
      ROP_OR_NDST:  res = src | ~dst;
      ROP_NSRC_OR:  res = ~src | dst;
      default:      res = '0;
    endcase
  end
endmodule

// File: rtl/rop_stage.sv
module rop_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  // R6: a stalled beat keeps its value and stays valid
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/rop_unit.sv
module rop_unit
  import rop_pkg::*;
#(
  parameter int CW = CH_W,
  parameter int NC = NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CW*NC-1:0]  src_pixel,
  input  logic [CW*NC-1:0]  dst_pixel,
  input  logic [CW*NC-1:0]  blend_pixel,
  input  logic [3:0]        op_code,
  input  logic              blend_en,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CW*NC-1:0]  out_pixel
);
  localparam int PIX_W = CW * NC;

  logic [PIX_W-1:0] logic_pix;
  logic [PIX_W-1:0] next_pix;

  for (genvar c = 0; c < NC; c++) begin : g_lane
    rop_lane #(.W(CW)) u_lane (
      .code (op_code),
      .src  (src_pixel[c*CW +: CW]),
      .dst  (dst_pixel[c*CW +: CW]),
      .res  (logic_pix[c*CW +: CW])
    );
  end

  assign next_pix = blend_en ? blend_pixel : logic_pix;

  rop_stage #(.W(PIX_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (next_pix),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_pixel)
  );

  logic took;
  assign took = in_valid && in_ready;

  // R5: an accepted beat is presented on the next cycle
  assert_take_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> out_valid);

  // R4: blend enabled forwards the blend pixel
  assert_blend_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (took && blend_en) |=> (out_pixel == $past(blend_pixel)));

  // R1: set code yields all ones
  assert_set_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (took && !blend_en && op_code == 4'd4) |=> (out_pixel == {PIX_W{1'b1}}));

  // R1: copy code yields the source pixel
  assert_copy_src_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (took && !blend_en && op_code == 4'd3) |=> (out_pixel == $past(src_pixel)));

  // R9: downstream ready opens the input
  assert_ready_flow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);
endmodule

// File: tb/tb_rop_unit.sv
module tb_rop_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] src_pixel = '0, dst_pixel = '0, blend_pixel = '0;
  logic [3:0]  op_code = '0;
  logic        blend_en = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_pixel;

  int total = 0, bad = 0;
  logic [31:0] expq[$];
  bit rand_ready = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rop_unit dut (.*);

  function automatic logic [7:0] ch_op(input logic [3:0] c, input logic [7:0] s, input logic [7:0] d);
    case (c)
      4'd0: return 8'h00;            4'd1: return s & d;
      4'd2: return s & ~d;           4'd3: return s;
      4'd4: return 8'hFF;            4'd5: return ~s;
      4'd6: return d;                4'd7: return ~d;
      4'd8: return ~(s & d);         4'd9: return s | d;
      4'd10: return ~(s | d);        4'd11: return s ^ d;
      4'd12: return ~(s ^ d);        4'd13: return ~s & d;
      4'd14: return s | ~d;          default: return ~s | d;
    endcase
  endfunction

  function automatic logic [31:0] model(input logic [3:0] c, input logic [31:0] s,
                                        input logic [31:0] d, input logic [31:0] b, input logic be);
    logic [31:0] r;
    if (be) return b;
    for (int k = 0; k < 4; k++) r[k*8 +: 8] = ch_op(c, s[k*8 +: 8], d[k*8 +: 8]);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: pushes expected result on acceptance
  task automatic send(input logic [31:0] s, input logic [31:0] d, input logic [31:0] b,
                      input logic [3:0] c, input logic be);
    @(negedge clk);
    src_pixel = s; dst_pixel = d; blend_pixel = b; op_code = c; blend_en = be;
    in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    expq.push_back(model(c, s, d, b, be));
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  // downstream ready, changed just after each edge
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = rand_ready ? lfsr[0] : 1'b1;
  end

  // monitor: compare produced beats, watch stalls
  logic [31:0] held;
  bit stalled = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stalled) begin
        check(out_valid && out_pixel == held, "R6 stall hold", out_pixel, held);
      end
      if (out_valid && !out_ready) check(!in_ready, "R6 in_ready low", {31'd0, in_ready}, 32'd0);
      if (out_ready) check(in_ready, "R9 in_ready follows out_ready", {31'd0, in_ready}, 32'd1);
      stalled = out_valid && !out_ready;
      held = out_pixel;
      if (out_valid && out_ready) begin
        if (expq.size() == 0) check(0, "R5 unexpected beat", out_pixel, 32'hx);
        else begin
          logic [31:0] e;
          e = expq.pop_front();
          check(out_pixel == e, "R1/R2/R3/R4/R7 result", out_pixel, e);
        end
      end
    end
  end

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          total++; bad++;
          $display("FAIL watchdog expired actual=running expected=done");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        check(!out_valid && in_ready, "R8 reset state", {30'd0, out_valid, in_ready}, 32'd1);
        rst_n = 1'b1;
        // R1, R2, R3: every code with distinct bytes per channel
        for (int c = 0; c < 16; c++)
          send(32'hF0CC_5A0F, 32'h0FAA_3CFF, 32'h1234_5678, c[3:0], 1'b0);
        // R5: one cycle latency
        send(32'h0102_0304, 32'h0, 32'h0, 4'd3, 1'b0);
        @(negedge clk);
        check(out_valid, "R5 latency", {31'd0, out_valid}, 32'd1);
        // R4: blend pass-through under several op codes
        send(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 4'd4, 1'b1);
        send(32'h0, 32'h0, 32'h0BAD_F00D, 4'd0, 1'b1);
        // R7: op change after acceptance has no effect
        send(32'hAAAA_AAAA, 32'h5555_5555, 32'h0, 4'd9, 1'b0);
        op_code = 4'd0; blend_en = 1'b1;
        repeat (3) @(negedge clk);
        // random traffic with back-pressure (R6)
        rand_ready = 1;
        for (int n = 0; n < 300; n++)
          send($urandom, $urandom, $urandom, 4'($urandom), 1'($urandom));
        while (expq.size() != 0) @(negedge clk);
        rand_ready = 0;
        repeat (4) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join
  end
endmodule